// File: doc/BRIEF.md
# Word-Fed CRC-32 Engine with Reflection Controls

This block computes a 32-bit cyclic redundancy check over a message that arrives as 32-bit words. Each accepted full word is folded into a stored 32-bit remainder in a single clock cycle. The fold is most-significant-bit first and uses the generator polynomial 0x04C11DB7. Messages whose length is not a multiple of four bytes end with one partial word of one to three bytes. The block folds that partial word one byte per cycle, so a message of any byte length can be processed.

Three mode inputs select how the data is treated. One reverses the bit order of incoming data. One reverses the bit order of the result. One inverts the result. With all three set, the output is the widely used reflected, inverted CRC-32. With all three clear, the output is the raw remainder. The result is formed combinationally from the stored remainder, so the presentation can be changed at any time without disturbing a computation in progress. A synchronous soft reset starts a new message by loading all ones into the remainder.

Top module: `crc32_word_engine`

## Requirements
- R1: After `rst_n` is released, the remainder is 0xFFFFFFFF, `ready` is 1, and with all mode inputs 0 `crc_out` reads 0xFFFFFFFF.
- R2: A full word is accepted when `data_valid`=1, `ready`=1 and `byte_count`=0. It is folded MSB-first with polynomial 0x04C11DB7, feeding bits data_in[31] down to data_in[0] when `rev_in`=0 and data_in[0] up to data_in[31] when `rev_in`=1. The new remainder appears on `crc_out` after the next rising edge.
- R3: A `byte_count` of k in 1..3 accepts a partial word whose bytes occupy data_in[8k-1:0]; lanes above are ignored. The bytes are folded in lane order, lane 0 (data_in[7:0]) first, one byte per cycle starting at the accepting edge. Within a byte, bit 7 goes first when `rev_in`=0 and bit 0 goes first when `rev_in`=1.
- R4: After a partial word of k bytes is accepted, `ready` is low for exactly k-1 cycles.
- R5: While `ready` is low, `data_valid` has no effect on the result.
- R6: `crc_out` equals the remainder, bit-reversed when `rev_out`=1, then XORed with 0xFFFFFFFF when `inv_out`=1. Changing the mode inputs never changes the stored remainder.
- R7: `soft_reset`=1 at a rising edge loads 0xFFFFFFFF into the remainder and drops any pending tail bytes, so `ready` is 1 after that edge. It takes priority over `data_valid`.
- R8: With `rev_in`=0, writing the current raw remainder back as a full word leaves a remainder of zero.
- R9: With all three mode inputs set, the 75-byte test message (72 bytes as 18 words plus a 3-byte partial word) yields 0x0B5D0A7D, matching a byte-wise reflected CRC-32.
- R10: A full word (`byte_count`=0) completes in one cycle: `ready` stays 1 after it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_reset | input | 1 | Synchronous restart of the remainder to all ones |
| data_valid | input | 1 | Data word present this cycle |
| data_in | input | 32 | Message word; tail bytes sit in the low lanes |
| byte_count | input | 2 | 0 = full word, 1..3 = tail byte count |
| rev_in | input | 1 | Bit-reverse input data before folding |
| rev_out | input | 1 | Bit-reverse the remainder on the output |
| inv_out | input | 1 | Invert the output |
| crc_out | output | 32 | Presented CRC value |
| ready | output | 1 | High when a new word may be accepted |

## Verification
The bench builds the engine with its default parameters: a 32-bit remainder, 8-bit lanes and polynomial 0x04C11DB7. These are the values for which the known answer 0x0B5D0A7D and an independent right-shifting reflected reference both apply. The bench walks a table of messages of 0 to 7 bytes through all eight mode combinations, with a soft reset between messages. Every result is compared against a bit-serial model built from the requirements. Directed tests cover the stall length after a tail, words offered during a stall, a soft reset during a tail, the feedback-to-zero property, and mode changes on a finished result.

// File: rtl/crc32w_pkg.sv
package crc32w_pkg;

    localparam logic [31:0] CRC32_POLY = 32'h04C1_1DB7;

    typedef struct packed {
        logic rev_in;
        logic rev_out;
        logic inv_out;
    } crc_mode_t;

endpackage

// File: rtl/crc_bit_rev.sv
module crc_bit_rev #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    input  logic         en,
    output logic [W-1:0] dout
);
    logic [W-1:0] flipped;

    for (genvar i = 0; i < W; i++) begin : g_flip
        assign flipped[i] = din[W-1-i];
    end

    assign dout = en ? flipped : din;
endmodule

// File: rtl/crc_fold.sv
module crc_fold #(
    parameter int              CW   = 32,
    parameter int              DW   = 32,
    parameter logic [CW-1:0]   POLY = '0
) (
    input  logic [CW-1:0] rem_in,
    input  logic [DW-1:0] data,
    output logic [CW-1:0] rem_out
);
    // one stage per input bit, MSB of data first
    logic [DW:0][CW-1:0] stage;

    assign stage[0] = rem_in;

    for (genvar s = 0; s < DW; s++) begin : g_step
        logic fb;
        assign fb           = stage[s][CW-1] ^ data[DW-1-s];
        assign stage[s+1]   = {stage[s][CW-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign rem_out = stage[DW];
endmodule

// File: rtl/crc32_word_engine.sv
module crc32_word_engine
    import crc32w_pkg::*;
#(
    parameter int                CRC_W  = 32,
    parameter int                LANE_W = 8,
    parameter logic [CRC_W-1:0]  POLY   = CRC32_POLY,
    parameter logic [CRC_W-1:0]  INIT   = '1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   soft_reset,
    input  logic                                   data_valid,
    input  logic [CRC_W-1:0]                       data_in,
    input  logic [$clog2(CRC_W/LANE_W)-1:0]        byte_count,
    input  logic                                   rev_in,
    input  logic                                   rev_out,
    input  logic                                   inv_out,
    output logic [CRC_W-1:0]                       crc_out,
    output logic                                   ready
);
    localparam int LANES = CRC_W / LANE_W;
    localparam int CNT_W = $clog2(LANES);

    typedef struct packed {
        logic [CRC_W-1:0]        rem;
        logic [CRC_W-LANE_W-1:0] tail;
        logic [CNT_W-1:0]        left;
    } state_t;

    state_t    st_d, st_q;
    crc_mode_t mode;

    logic [CRC_W-1:0]  word_fed, rem_word, rem_view, rem_byte;
    logic [LANE_W-1:0] byte_raw, byte_fed;

    assign mode     = '{rev_in: rev_in, rev_out: rev_out, inv_out: inv_out};
    assign ready    = (st_q.left == '0);
    assign byte_raw = ready ? data_in[LANE_W-1:0] : st_q.tail[LANE_W-1:0];

    crc_bit_rev #(.W(CRC_W)) u_rev_word (
        .din(data_in), .en(mode.rev_in), .dout(word_fed));

    crc_bit_rev #(.W(LANE_W)) u_rev_byte (
        .din(byte_raw), .en(mode.rev_in), .dout(byte_fed));

    crc_fold #(.CW(CRC_W), .DW(CRC_W), .POLY(POLY)) u_fold_word (
        .rem_in(st_q.rem), .data(word_fed), .rem_out(rem_word));

    crc_fold #(.CW(CRC_W), .DW(LANE_W), .POLY(POLY)) u_fold_byte (
        .rem_in(st_q.rem), .data(byte_fed), .rem_out(rem_byte));

    crc_bit_rev #(.W(CRC_W)) u_rev_out (
        .din(st_q.rem), .en(mode.rev_out), .dout(rem_view));

    assign crc_out = rem_view ^ {CRC_W{mode.inv_out}};

    always_comb begin
        st_d = st_q;
        if (soft_reset) begin
            st_d.rem  = INIT;
            st_d.tail = '0;
            st_d.left = '0;
        end else if (!ready) begin
            st_d.rem  = rem_byte;
            st_d.tail = st_q.tail >> LANE_W;
            st_d.left = st_q.left - 1'b1;
        end else if (data_valid) begin
            if (byte_count == '0) begin
                st_d.rem = rem_word;
            end else begin
                st_d.rem  = rem_byte;
                st_d.tail = data_in[CRC_W-1:LANE_W];
                st_d.left = byte_count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rem: INIT, tail: '0, left: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // restart loads all ones and clears any stall
    assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |=> (st_q.rem == INIT) && ready);

    // no accepted input, no change to the remainder
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !data_valid && !soft_reset) |=> $stable(st_q.rem));

    // a tail of more than one byte stalls the interface
    assert_tail_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && data_valid && !soft_reset && byte_count > 1) |=> !ready);

    // during a stall only the pending tail advances, one byte per cycle
    assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !soft_reset) |=> (st_q.left == $past(st_q.left) - 1'b1));

    // full words never stall
    assert_word_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && data_valid && !soft_reset && byte_count == '0) |=> ready);
endmodule

// File: tb/crc32_word_engine_bench.sv
`timescale 1ns/1ps
module crc32_word_engine_bench;
    localparam logic [31:0] P = 32'h04C1_1DB7;
    // table: {length[2:0], seed[7:0]}
    localparam logic [10:0] VEC [8] = '{
        {3'd0, 8'h3C}, {3'd1, 8'h91}, {3'd2, 8'h07}, {3'd3, 8'hE2},
        {3'd4, 8'h5A}, {3'd5, 8'hC4}, {3'd6, 8'h18}, {3'd7, 8'hFF}};

    logic        clk = 1'b0, rst_n = 1'b0, soft_reset = 1'b0, data_valid = 1'b0;
    logic [31:0] data_in = '0;
    logic [1:0]  byte_count = '0;
    logic        rev_in = 1'b0, rev_out = 1'b0, inv_out = 1'b0;
    logic [31:0] crc_out;
    logic        ready;
    logic [7:0]  buf_b [80];
    int          n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    crc32_word_engine u_crc32_word_engine (
        .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset), .data_valid(data_valid),
        .data_in(data_in), .byte_count(byte_count), .rev_in(rev_in),
        .rev_out(rev_out), .inv_out(inv_out), .crc_out(crc_out), .ready(ready));

    function automatic logic [31:0] m_bit(input logic [31:0] r, input logic b);
        return {r[30:0], 1'b0} ^ ((r[31] ^ b) ? P : 32'h0);
    endfunction

    function automatic logic [31:0] m_word(input logic [31:0] r, input logic [31:0] w, input logic rv);
        for (int i = 0; i < 32; i++) r = m_bit(r, rv ? w[i] : w[31-i]);
        return r;
    endfunction

    function automatic logic [31:0] m_byte(input logic [31:0] r, input logic [7:0] b, input logic rv);
        for (int i = 0; i < 8; i++) r = m_bit(r, rv ? b[i] : b[7-i]);
        return r;
    endfunction

    function automatic logic [31:0] m_out(input logic [31:0] r, input logic [2:0] m);
        logic [31:0] v;
        for (int i = 0; i < 32; i++) v[i] = m[1] ? r[31-i] : r[i];
        return m[0] ? ~v : v;
    endfunction

    function automatic logic [7:0] kat_byte(input int i);
        logic [7:0] head [28] = '{8'hA1, 8'h11, 8'hC0, 8'h00, 8'h83, 8'h81, 8'h7E,
            8'h7E, 8'h08, 8'h00, 8'h3C, 8'h00, 8'h00, 8'h83, 8'hA2, 8'h07, 8'hF1,
            8'hFF, 8'hF9, 8'hFF, 8'h04, 8'h00, 8'h21, 8'h03, 8'h17, 8'h1F, 8'h29, 8'hF9};
        if (i < 28) return head[i];
        if (i == 33) return 8'h08;
        if (i == 38 || i == 42 || i == 47 || i == 51 || i == 56 || i == 60 ||
            i == 65 || i == 69) return 8'h80;
        return 8'h00;
    endfunction

    function automatic logic [31:0] ref_reflected(input int len);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < len; i++)
            for (int k = 0; k < 8; k++)
                c = (c >> 1) ^ ((c[0] ^ buf_b[i][k]) ? 32'hEDB8_8320 : 32'h0);
        return ~c;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        rev_in = m[2]; rev_out = m[1]; inv_out = m[0];
    endtask

    task automatic pulse_soft();
        @(negedge clk); soft_reset = 1'b1;
        @(negedge clk); soft_reset = 1'b0;
    endtask

    task automatic feed(input logic [31:0] w, input logic [1:0] bc);
        @(negedge clk);
        data_in = w; byte_count = bc; data_valid = 1'b1;
        @(negedge clk);
        data_valid = 1'b0;
        while (!ready) @(negedge clk);
    endtask

    // sends buf_b[0..len-1]; returns the modelled raw remainder
    task automatic send_buf(input int len, input logic rv, output logic [31:0] r);
        logic [31:0] w;
        int k;
        r = 32'hFFFF_FFFF;
        for (int i = 0; i + 4 <= len; i += 4) begin
            w = {buf_b[i+3], buf_b[i+2], buf_b[i+1], buf_b[i]};
            feed(w, 2'd0);
            r = m_word(r, w, rv);
        end
        k = len % 4;
        if (k != 0) begin
            w = 32'hA5A5_A5A5;
            for (int l = 0; l < k; l++) w[8*l +: 8] = buf_b[len - k + l];
            feed(w, 2'(k));
            for (int l = 0; l < k; l++) r = m_byte(r, w[8*l +: 8], rv);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R4 watchdog: actual hang expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset remainder", crc_out, 32'hFFFF_FFFF);
        check("R1 reset ready", {31'b0, ready}, 32'd1);

        // table walk: every length 0..7 under every mode combination
        for (int t = 0; t < 8; t++) begin
            for (int m = 0; m < 8; m++) begin
                pulse_soft();
                set_mode(3'(m));
                for (int j = 0; j < 8; j++) buf_b[j] = 8'(int'(VEC[t][7:0]) + j * 37);
                send_buf(int'(VEC[t][10:8]), rev_in, r);
                @(negedge clk);
                check($sformatf("R2 R3 R6 len %0d mode %0d", VEC[t][10:8], m),
                      crc_out, m_out(r, 3'(m)));
            end
        end

        // known-answer message, reflected and inverted
        pulse_soft();
        set_mode(3'b111);
        for (int i = 0; i < 75; i++) buf_b[i] = kat_byte(i);
        send_buf(75, 1'b1, r);
        @(negedge clk);
        check("R9 known answer", crc_out, 32'h0B5D_0A7D);
        check("R9 reflected reference", crc_out, ref_reflected(75));

        // mode changes only alter the view
        for (int m = 0; m < 8; m++) begin
            set_mode(3'(m));
            #1 check($sformatf("R6 view mode %0d", m), crc_out, m_out(r, 3'(m)));
        end
        set_mode(3'b111);
        #1 check("R6 remainder kept", crc_out, 32'h0B5D_0A7D);

        // stall length after a 3-byte tail
        set_mode(3'b000);
        pulse_soft();
        @(negedge clk);
        data_in = 32'h00C3_B2A1; byte_count = 2'd3; data_valid = 1'b1;
        @(negedge clk); data_valid = 1'b0;
        check("R4 stall cycle 1", {31'b0, ready}, 32'd0);
        @(negedge clk);
        check("R4 stall cycle 2", {31'b0, ready}, 32'd0);
        @(negedge clk);
        check("R4 ready after stall", {31'b0, ready}, 32'd1);
        exp = m_byte(m_byte(m_byte(32'hFFFF_FFFF, 8'hA1, 1'b0), 8'hB2, 1'b0), 8'hC3, 1'b0);
        check("R3 three-byte tail", crc_out, exp);

        // single-byte tail and full word never stall
        pulse_soft();
        @(negedge clk);
        data_in = 32'hFFFF_FF5E; byte_count = 2'd1; data_valid = 1'b1;
        @(negedge clk); data_valid = 1'b0;
        check("R4 one-byte tail no stall", {31'b0, ready}, 32'd1);
        check("R3 upper lanes ignored", crc_out, m_byte(32'hFFFF_FFFF, 8'h5E, 1'b0));
        @(negedge clk);
        data_in = 32'h1234_5678; byte_count = 2'd0; data_valid = 1'b1;
        exp = m_word(m_byte(32'hFFFF_FFFF, 8'h5E, 1'b0), 32'h1234_5678, 1'b0);
        @(negedge clk); data_valid = 1'b0;
        check("R10 word ready stays high", {31'b0, ready}, 32'd1);
        check("R10 word folded in one cycle", crc_out, exp);

        // word offered during a stall is dropped
        pulse_soft();
        @(negedge clk);
        data_in = 32'h0000_6C4D; byte_count = 2'd2; data_valid = 1'b1;
        @(negedge clk);
        data_in = 32'hDEAD_BEEF; byte_count = 2'd0; data_valid = 1'b1;
        @(negedge clk); data_valid = 1'b0;
        @(negedge clk);
        exp = m_byte(m_byte(32'hFFFF_FFFF, 8'h4D, 1'b0), 8'h6C, 1'b0);
        check("R5 busy write ignored", crc_out, exp);

        // soft reset during a tail, with a word offered at the same edge
        @(negedge clk);
        data_in = 32'h0011_2233; byte_count = 2'd3; data_valid = 1'b1;
        @(negedge clk);
        soft_reset = 1'b1; data_in = 32'hCAFE_F00D; byte_count = 2'd0;
        @(negedge clk);
        soft_reset = 1'b0; data_valid = 1'b0;
        check("R7 ready after abort", {31'b0, ready}, 32'd1);
        check("R7 remainder restarted", crc_out, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R7 no late tail byte", crc_out, 32'hFFFF_FFFF);

        // remainder fed back on itself clears it
        feed(32'h8badf00d, 2'd0);
        feed(crc_out, 2'd0);
        check("R8 feedback zero", crc_out, 32'h0);

        finish_run();
    end
endmodule